// File: doc/BRIEF.md
# Interrupt Enable, Pending and Delegation Register Unit

This unit holds the machine-level interrupt enable, interrupt pending and interrupt delegation state of a 32-bit hart. Each of the three registers is 64 bits wide. Software reaches each one through a 32-bit CSR port that has a low-half address and a high-half address. The high-half addresses exist only when the extended interrupt feature is enabled (`HAS_HIGH`). When it is disabled, an access to a high-half address is illegal.

Reads pass through a visibility mask. The privilege mode for that mask comes from CSR address bits 9:8. Writes pass through a per-register writability mask. Hardware pending sources are merged into the pending view and cannot be overwritten by software. Every accepted write to the enable register raises a one-cycle strobe, so the interrupt selection logic downstream re-evaluates eligibility.

All outputs are registered and refer to the request presented one clock earlier. Reset is synchronous and active high.

Top module: `irq_csr_unit`

## Requirements
- R1: After reset all three registers are zero, and `csr_rdata_o`, `csr_illegal_o` and `recheck_o` are 0.
- R2: Register addresses are enable 0x304/0x314, pending 0x344/0x354 and delegation 0x303/0x313 (low/high). A read of the low address returns bits 31:0 of the visible value, and a read of the high address returns bits 63:32.
- R3: A low-half write changes no bit in 63:32, and a high-half write changes no bit in 31:0. In both cases the written word lands in that half.
- R4: With the default custom mask, the enable bits software can write are 63:16, 11, 7 and 3. Bits 10:8, 6:4, 2:0 and 15:12 keep their value, which is zero after reset.
- R5: In the pending register, bits 11, 7 and 3 (the default `HW_PEND_MASK`) read as `hw_pend_i` sampled in the request cycle, and software writes to them are ignored. Pending bits 63:16, 10:8, 6:4 and 2:0 are written by software.
- R6: The writable delegation mask is 0x0000_0000_FFFF_0111. A high-half delegation write is accepted as legal but leaves the register unchanged.
- R7: A read is ANDed with the mode mask selected by address bits 9:8. That mask sets bits 63:16 and sets the low 12 bits to 0x111, 0x333, 0x777 or 0xFFF for mode 0 to 3. For the machine addresses, bits 15:12 read as zero.
- R8: `recheck_o` is high for exactly the cycle after each legal write to either enable address. Writes to other registers never raise it.
- R9: An access to any other address, or to a high-half address when `HAS_HIGH` is 0, raises `csr_illegal_o` in the next cycle with `csr_rdata_o` = 0 and changes no state.
- R10: `csr_rdata_o` is valid the cycle after the read and is zero when no legal read was requested. A read and a write to the same address in one cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | Write word |
| csr_we_i | input | 1 | Write request |
| csr_re_i | input | 1 | Read request |
| hw_pend_i | input | 64 | Hardware pending sources |
| csr_rdata_o | output | 32 | Registered read word |
| csr_illegal_o | output | 1 | Registered illegal-access flag |
| recheck_o | output | 1 | One-cycle re-evaluate strobe after enable writes |

## Verification
Two events can land in the same cycle. The first is a read and a write to the same register: the bench drives both requests together on the enable and pending addresses. The returned word must hold the old contents, and the next read must show the update. The second is a software write to the pending register while `hw_pend_i` toggles: the hardware-owned bits must follow the input and ignore the written value. A second instance built without high halves receives the same stimulus, so each high-half access is judged as illegal on one instance and legal on the other.

// File: rtl/irq_csr_pkg.sv
`timescale 1ns/1ps
package irq_csr_pkg;
  localparam int HALF_W = 32;
  localparam int FULL_W = 2 * HALF_W;
  localparam int ADDR_W = 12;
  localparam int GRP_W  = 4;
  localparam int STD_W  = 3 * GRP_W;
  localparam int LOCAL_LO = 16;

  localparam logic [ADDR_W-1:0] A_EN_LO = 12'h304;
  localparam logic [ADDR_W-1:0] A_EN_HI = 12'h314;
  localparam logic [ADDR_W-1:0] A_PD_LO = 12'h344;
  localparam logic [ADDR_W-1:0] A_PD_HI = 12'h354;
  localparam logic [ADDR_W-1:0] A_DG_LO = 12'h303;
  localparam logic [ADDR_W-1:0] A_DG_HI = 12'h313;

  localparam logic [FULL_W-1:0] STD_EN_BITS = 64'h0000_0000_0000_0777;
  localparam logic [FULL_W-1:0] DELEG_WMASK = 64'h0000_0000_FFFF_0111;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_EN   = 2'd1,
    SEL_PD   = 2'd2,
    SEL_DG   = 2'd3
  } reg_sel_e;

  // Visibility mask for a privilege mode: all local bits plus a per-group
  // prefix of (mode+1) bits in each of the three standard groups.
  function automatic logic [FULL_W-1:0] view_mask(input logic [1:0] mode);
    logic [GRP_W-1:0] grp;
    logic [FULL_W-1:0] m;
    grp = GRP_W'((5'd2 << mode) - 5'd1);
    m = '0;
    m[FULL_W-1:LOCAL_LO] = '1;
    m[STD_W-1:0] = {grp, grp, grp};
    return m;
  endfunction
endpackage

// File: rtl/irq_csr_decode.sv
`timescale 1ns/1ps
module irq_csr_decode import irq_csr_pkg::*; #(
  parameter bit HAS_HIGH = 1'b1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic              hi_o,
  output logic              legal_o,
  output logic [1:0]        mode_o
);
  reg_sel_e lo_sel, hi_sel;

  always_comb begin
    case (addr_i)
      A_EN_LO: lo_sel = SEL_EN;
      A_PD_LO: lo_sel = SEL_PD;
      A_DG_LO: lo_sel = SEL_DG;
      default: lo_sel = SEL_NONE;
    endcase
  end

  generate
    if (HAS_HIGH) begin : g_high
      always_comb begin
        case (addr_i)
          A_EN_HI: hi_sel = SEL_EN;
          A_PD_HI: hi_sel = SEL_PD;
          A_DG_HI: hi_sel = SEL_DG;
          default: hi_sel = SEL_NONE;
        endcase
      end
    end else begin : g_no_high
      assign hi_sel = SEL_NONE;
    end
  endgenerate

  always_comb begin
    hi_o    = (hi_sel != SEL_NONE);
    sel_o   = hi_o ? hi_sel : lo_sel;
    legal_o = (sel_o != SEL_NONE);
    mode_o  = addr_i[9:8];
  end
endmodule

// File: rtl/irq_csr_split_reg.sv
`timescale 1ns/1ps
module irq_csr_split_reg import irq_csr_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              hi_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic [FULL_W-1:0] wmask_i,
  output logic [FULL_W-1:0] q_o
);
  logic [FULL_W-1:0] lane, placed, eff;

  always_comb begin
    lane   = hi_i ? {{HALF_W{1'b1}}, {HALF_W{1'b0}}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    placed = hi_i ? {wdata_i, {HALF_W{1'b0}}} : {{HALF_W{1'b0}}, wdata_i};
    eff    = lane & wmask_i;
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else if (wr_i) q_o <= (q_o & ~eff) | (placed & eff);
  end

  // R3
  lo_write_keeps_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !hi_i) |=> $stable(q_o[FULL_W-1:HALF_W]));
  // R3
  hi_write_keeps_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && hi_i) |=> $stable(q_o[HALF_W-1:0]));
  // R4
  fixed_bits_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (((q_o ^ $past(q_o)) & ~$past(wmask_i)) == '0));
endmodule

// File: rtl/irq_csr_rdmux.sv
`timescale 1ns/1ps
module irq_csr_rdmux import irq_csr_pkg::*; (
  input  reg_sel_e          sel_i,
  input  logic              hi_i,
  input  logic [1:0]        mode_i,
  input  logic [FULL_W-1:0] en_i,
  input  logic [FULL_W-1:0] pd_i,
  input  logic [FULL_W-1:0] dg_i,
  output logic [HALF_W-1:0] word_o
);
  logic [FULL_W-1:0] full, shown;

  always_comb begin
    case (sel_i)
      SEL_EN:  full = en_i;
      SEL_PD:  full = pd_i;
      SEL_DG:  full = dg_i;
      default: full = '0;
    endcase
    shown  = full & view_mask(mode_i);
    word_o = hi_i ? shown[FULL_W-1:HALF_W] : shown[HALF_W-1:0];
  end
endmodule

// File: rtl/irq_csr_unit.sv
`timescale 1ns/1ps
module irq_csr_unit import irq_csr_pkg::*; #(
  parameter bit                HAS_HIGH       = 1'b1,
  parameter logic [FULL_W-1:0] EN_CUSTOM_MASK = '1,
  parameter logic [FULL_W-1:0] HW_PEND_MASK   = 64'h0000_0000_0000_0888
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic [HALF_W-1:0] csr_wdata_i,
  input  logic              csr_we_i,
  input  logic              csr_re_i,
  input  logic [FULL_W-1:0] hw_pend_i,
  output logic [HALF_W-1:0] csr_rdata_o,
  output logic              csr_illegal_o,
  output logic              recheck_o
);
  reg_sel_e          sel;
  logic              hi, legal;
  logic [1:0]        mode;
  logic [FULL_W-1:0] vmask, en_q, pd_q, dg_q, pd_view;
  logic [FULL_W-1:0] en_wm, pd_wm, dg_wm;
  logic              wr_ok, en_wr, pd_wr, dg_wr;
  logic [HALF_W-1:0] rd_word;

  irq_csr_decode #(.HAS_HIGH(HAS_HIGH)) u_dec (
    .addr_i(csr_addr_i), .sel_o(sel), .hi_o(hi), .legal_o(legal), .mode_o(mode)
  );

  always_comb begin
    vmask = view_mask(mode);
    en_wm = vmask & EN_CUSTOM_MASK & ~STD_EN_BITS;
    pd_wm = vmask & ~HW_PEND_MASK;
    dg_wm = vmask & DELEG_WMASK;
    wr_ok = csr_we_i && legal;
    en_wr = wr_ok && (sel == SEL_EN);
    pd_wr = wr_ok && (sel == SEL_PD);
    dg_wr = wr_ok && (sel == SEL_DG);
    pd_view = (pd_q & ~HW_PEND_MASK) | (hw_pend_i & HW_PEND_MASK);
  end

  irq_csr_split_reg u_en (
    .clk(clk), .rst(rst), .wr_i(en_wr), .hi_i(hi), .wdata_i(csr_wdata_i),
    .wmask_i(en_wm), .q_o(en_q)
  );
  irq_csr_split_reg u_pd (
    .clk(clk), .rst(rst), .wr_i(pd_wr), .hi_i(hi), .wdata_i(csr_wdata_i),
    .wmask_i(pd_wm), .q_o(pd_q)
  );
  irq_csr_split_reg u_dg (
    .clk(clk), .rst(rst), .wr_i(dg_wr), .hi_i(hi), .wdata_i(csr_wdata_i),
    .wmask_i(dg_wm), .q_o(dg_q)
  );

  irq_csr_rdmux u_mux (
    .sel_i(sel), .hi_i(hi), .mode_i(mode), .en_i(en_q), .pd_i(pd_view),
    .dg_i(dg_q), .word_o(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata_o   <= '0;
      csr_illegal_o <= 1'b0;
      recheck_o     <= 1'b0;
    end else begin
      csr_rdata_o   <= (csr_re_i && legal) ? rd_word : '0;
      csr_illegal_o <= (csr_re_i || csr_we_i) && !legal;
      recheck_o     <= en_wr;
    end
  end

  // R8
  recheck_follows_en_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_we_i && legal && sel == SEL_EN) |=> recheck_o);
  // R8
  recheck_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    recheck_o |-> $past(csr_we_i));
  // R9
  illegal_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    csr_illegal_o |-> (csr_rdata_o == '0));
  // R10
  idle_outputs_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(csr_re_i || csr_we_i) |=> (!csr_illegal_o && csr_rdata_o == '0 && !recheck_o));
endmodule

// File: tb/irq_csr_unit_tb.sv
`timescale 1ns/1ps
module irq_csr_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic        csr_we = 1'b0, csr_re = 1'b0;
  logic [63:0] hw_pend = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        ill_a, ill_b, rc_a, rc_b;

  int checks = 0;
  int fails  = 0;

  // reference state
  logic [63:0] m_en = '0, m_pd = '0, m_dg = '0;

  always #2.5 clk = ~clk;

  irq_csr_unit u_dut (
    .clk(clk), .rst(rst), .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata),
    .csr_we_i(csr_we), .csr_re_i(csr_re), .hw_pend_i(hw_pend),
    .csr_rdata_o(rdata_a), .csr_illegal_o(ill_a), .recheck_o(rc_a)
  );

  irq_csr_unit #(.HAS_HIGH(1'b0)) u_dut_nohi (
    .clk(clk), .rst(rst), .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata),
    .csr_we_i(csr_we), .csr_re_i(csr_re), .hw_pend_i(hw_pend),
    .csr_rdata_o(rdata_b), .csr_illegal_o(ill_b), .recheck_o(rc_b)
  );

  task automatic report(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive, predict, advance the model, compare after the edge.
  task automatic step(input logic [11:0] a, input logic [31:0] d, input bit we,
                      input bit re, input logic [63:0] hw, input string tag);
    int r; bit hi, ok, ok_lo, e_ill, e_ill_b, e_rc;
    logic [63:0] view, lane, placed, wm;
    logic [31:0] e_rd, e_rd_b;
    r = 0; hi = 0;
    if (a == 12'h304) r = 1; else if (a == 12'h314) begin r = 1; hi = 1; end
    else if (a == 12'h344) r = 2; else if (a == 12'h354) begin r = 2; hi = 1; end
    else if (a == 12'h303) r = 3; else if (a == 12'h313) begin r = 3; hi = 1; end
    ok = (r != 0);
    ok_lo = ok && !hi;
    csr_addr = a; csr_wdata = d; csr_we = we; csr_re = re; hw_pend = hw;
    case (r)
      1: view = m_en;
      2: view = (m_pd & ~64'h888) | (hw & 64'h888);
      3: view = m_dg;
      default: view = '0;
    endcase
    view = view & 64'hFFFF_FFFF_FFFF_0FFF;
    e_rd   = (re && ok) ? (hi ? view[63:32] : view[31:0]) : 32'h0;
    e_rd_b = (re && ok_lo) ? e_rd : 32'h0;
    e_ill   = (we || re) && !ok;
    e_ill_b = (we || re) && !ok_lo;
    e_rc = we && ok && (r == 1);
    if (we && ok) begin
      lane   = hi ? 64'hFFFF_FFFF_0000_0000 : 64'h0000_0000_FFFF_FFFF;
      placed = hi ? {d, 32'h0} : {32'h0, d};
      case (r)
        1: wm = 64'hFFFF_FFFF_FFFF_0888;
        2: wm = 64'hFFFF_FFFF_FFFF_0777;
        default: wm = 64'h0000_0000_FFFF_0111;
      endcase
      wm = wm & lane;
      if (r == 1) m_en = (m_en & ~wm) | (placed & wm);
      if (r == 2) m_pd = (m_pd & ~wm) | (placed & wm);
      if (r == 3) m_dg = (m_dg & ~wm) | (placed & wm);
    end
    @(posedge clk);
    @(negedge clk);
    report(rdata_a == e_rd, tag, "rdata", rdata_a, e_rd);
    report(ill_a == e_ill, tag, "illegal", 32'(ill_a), 32'(e_ill));
    report(rc_a == e_rc, tag, "recheck", 32'(rc_a), 32'(e_rc));
    report(rdata_b == e_rd_b, tag, "nohi rdata", rdata_b, e_rd_b);
    report(ill_b == e_ill_b, tag, "nohi illegal", 32'(ill_b), 32'(e_ill_b));
  endtask

  task automatic rd(input logic [11:0] a, input logic [63:0] hw, input string tag);
    step(a, 32'h0, 1'b0, 1'b1, hw, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    step(a, d, 1'b1, 1'b0, 64'h0, tag);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    step(12'h000, 32'h0, 1'b0, 1'b0, 64'h0, "R1");
    rd(12'h304, 64'h0, "R1"); rd(12'h314, 64'h0, "R1");
    rd(12'h344, 64'h0, "R1"); rd(12'h354, 64'h0, "R1");
    rd(12'h303, 64'h0, "R1"); rd(12'h313, 64'h0, "R1");
    // R4 R8 enable low write
    wr(12'h304, 32'hFFFF_FFFF, "R8");
    rd(12'h304, 64'h0, "R4");
    rd(12'h314, 64'h0, "R3");
    // R3 R8 enable high write
    wr(12'h314, 32'hA5A5_5A5A, "R3");
    rd(12'h314, 64'h0, "R2");
    rd(12'h304, 64'h0, "R3");
    // R5 R7 pending
    wr(12'h344, 32'hFFFF_FFFF, "R5");
    rd(12'h344, 64'h0, "R7");
    rd(12'h344, 64'h8, "R5");
    rd(12'h344, 64'h1000, "R7");
    step(12'h344, 32'h0, 1'b1, 1'b1, 64'h880, "R5");
    rd(12'h344, 64'h880, "R5");
    wr(12'h354, 32'h1234_5678, "R3");
    rd(12'h354, 64'h8_0000_0000, "R2");
    // R6 delegation
    wr(12'h303, 32'hFFFF_FFFF, "R6");
    rd(12'h303, 64'h0, "R6");
    wr(12'h313, 32'hFFFF_FFFF, "R6");
    rd(12'h313, 64'h0, "R6");
    // R10 read+write in one cycle
    step(12'h304, 32'h0000_0008, 1'b1, 1'b1, 64'h0, "R10");
    rd(12'h304, 64'h0, "R10");
    // R9 illegal addresses
    wr(12'h305, 32'hFFFF_FFFF, "R9");
    rd(12'h305, 64'h0, "R9");
    rd(12'h104, 64'h0, "R9");
    rd(12'h314, 64'h0, "R9");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      int k;
      k = int'($urandom_range(7, 0));
      case (k)
        0: a = 12'h304; 1: a = 12'h314; 2: a = 12'h344; 3: a = 12'h354;
        4: a = 12'h303; 5: a = 12'h313; 6: a = 12'h305; default: a = 12'h000;
      endcase
      step(a, $urandom(), 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
           {$urandom(), $urandom()}, "R2");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule